// File: doc/BRIEF.md
# Manchester Transmit Framer with Sync Delimiter

This block puts characters onto one serial transmit line as Manchester-coded frames. A frame has three parts, sent in this order. First comes an optional preamble of up to fifteen bits, drawn from one of four fixed patterns. Next comes a start delimiter. Last come eight data bits, sent least significant bit first. The line rests high whenever no frame is in flight.

The delimiter takes one of two forms. The first is a plain start bit: a Manchester-coded zero. The second is a three-bit-time sync waveform. The sync waveform breaks the Manchester rules on purpose, because its only level change falls halfway through its second bit time. That makes the waveform easy to tell apart from data. Its polarity tells a receiver what the character is:
- A command sync is high for 1.5 bit times, then low for 1.5 bit times.
- A data sync is the reverse: low first, then high.

A global configuration bit chooses between command and data. When variable-sync mode is on, each character brings its own command/data flag instead, and the global bit is ignored.

Characters arrive over a valid/ready handshake. Ready is high only while the framer is idle. All configuration and the per-character flag are captured at the moment of acceptance. Each half-bit time is a whole number of system clocks, set by a divisor of at least two.

Top module: `mtx_framer`

## Requirements
- R1: After reset, and between frames, `tx_line` is 1, `busy` is 0 and `chr_ready` is 1. Asserting `rst_n` low in the middle of a frame returns the block to this idle state.
- R2: A character is accepted on a rising clock edge at which `chr_valid` and `chr_ready` are both 1. From the next cycle until the frame ends, `busy` is 1 and `chr_ready` is 0. A `chr_valid` that arrives while `busy` is 1 is not accepted.
- R3: Let D = `cfg_div`, or D = 2 when `cfg_div` is below 2, taken at acceptance. Every half-bit lasts exactly D clocks. The frame lasts H×D clocks, where H = 2×`cfg_pre_len` + (6 if `cfg_sync_en` is 1, else 2) + 16. `busy` falls H×D clocks after the accepting edge.
- R4: A one is sent as high then low, and a zero as low then high. The eight data bits of `chr_data` follow the delimiter, bit 0 first.
- R5: The preamble has `cfg_pre_len` bits, and 0 means no preamble. The bit k of the preamble (k = 0 is sent first) depends on `cfg_pre_sel`:
  - 0: all ones.
  - 1: all zeros.
  - 2: bit k is 0 for even k and 1 for odd k.
  - 3: bit k is 1 for even k and 0 for odd k.
- R6: With `cfg_sync_en` = 0, the delimiter is one Manchester-coded zero: low half, then high half.
- R7: With `cfg_sync_en` = 1, the delimiter is six half-bits long. A command sync is 3 halves high, then 3 halves low. A data sync is 3 halves low, then 3 halves high.
- R8: With `cfg_var_sync` = 0, `cfg_cmd` = 1 selects a command sync and 0 selects a data sync. With `cfg_var_sync` = 1, `chr_cmd` makes the same choice and `cfg_cmd` has no effect.
- R9: Changes to the configuration inputs, `chr_data` or `chr_cmd` after acceptance have no effect on the frame in progress.
- R10: While `busy` is 1, `tx_line` changes only at half-bit boundaries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div | input | DIV_W | Clocks per half-bit (values below 2 act as 2) |
| cfg_pre_sel | input | 2 | Preamble pattern select |
| cfg_pre_len | input | LEN_W | Preamble length in bits |
| cfg_sync_en | input | 1 | 1: sync delimiter, 0: single start bit |
| cfg_cmd | input | 1 | Global command (1) / data (0) sync choice |
| cfg_var_sync | input | 1 | 1: take sync type from chr_cmd |
| chr_valid | input | 1 | Character offered |
| chr_data | input | DATA_W | Character data |
| chr_cmd | input | 1 | Per-character command/data sync flag |
| chr_ready | output | 1 | Framer idle, can accept a character |
| tx_line | output | 1 | Manchester-coded serial line |
| busy | output | 1 | Frame in progress |

## Verification
Four properties are checked on every cycle:
- The line rests high whenever the framer is not busy.
- A frame starts only after a handshake.
- The line holds steady between half-bit ticks.
- A frame ends only on a half-bit tick.

The rest needs the bench's scenarios, because it depends on the captured configuration:
- the exact half-bit sequence of each preamble pattern;
- the polarity of the command and data syncs;
- the choice between the global and the per-character sync flag;
- the frame length for a given divisor;
- immunity to input changes during a frame.

// File: rtl/mtx_pkg.sv
package mtx_pkg;

  typedef enum logic [1:0] {
    PRE_ONES     = 2'd0,
    PRE_ZEROS    = 2'd1,
    PRE_ZERO_ONE = 2'd2,
    PRE_ONE_ZERO = 2'd3
  } pre_e;

  typedef struct packed {
    pre_e sel;
    logic sync_en;
    logic cmd;
  } frame_cfg_t;

endpackage

// File: rtl/mtx_tick.sv
module mtx_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_d;

  assign tick = run && (cnt_q == div - 1'b1);

  always_comb begin
    cnt_d = cnt_q;
    if (restart) begin
      cnt_d = '0;
    end else if (run) begin
      cnt_d = tick ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/mtx_level.sv
module mtx_level
  import mtx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 4,
  parameter int N_W    = 6
) (
  input  logic [N_W-1:0]    n,
  input  logic [LEN_W-1:0]  pre_len,
  input  frame_cfg_t        cfg,
  input  logic [DATA_W-1:0] data,
  output logic              level,
  output logic [N_W-1:0]    last_n
);

  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  logic [N_W-1:0] pre_h;
  logic [N_W-1:0] sfd_h;
  logic [N_W-1:0] m;
  logic [N_W-1:0] d;
  logic [N_W-1:0] d_bit;
  logic [N_W-1:0] k_bit;
  logic           pre_bit;
  logic           sym;

  assign pre_h  = N_W'(pre_len) << 1;
  assign sfd_h  = cfg.sync_en ? N_W'(6) : N_W'(2);
  assign last_n = pre_h + sfd_h + N_W'(2 * DATA_W) - 1'b1;
  assign m      = n - pre_h;
  assign d      = m - sfd_h;
  assign d_bit  = d >> 1;
  assign k_bit  = n >> 1;

  always_comb begin
    unique case (cfg.sel)
      PRE_ONES:     pre_bit = 1'b1;
      PRE_ZEROS:    pre_bit = 1'b0;
      PRE_ZERO_ONE: pre_bit = k_bit[0];
      default:      pre_bit = ~k_bit[0];
    endcase
  end

  always_comb begin
    sym = 1'b1;
    if (n < pre_h) begin
      sym = n[0] ? ~pre_bit : pre_bit;
    end else if (m < sfd_h) begin
      if (cfg.sync_en) begin
        sym = (m < N_W'(3)) ? cfg.cmd : ~cfg.cmd;
      end else begin
        sym = m[0];
      end
    end else begin
      sym = n[0] ? ~data[d_bit[IDX_W-1:0]] : data[d_bit[IDX_W-1:0]];
    end
  end

  assign level = sym;

endmodule

// File: rtl/mtx_seq.sv
module mtx_seq
  import mtx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 4,
  parameter int DIV_W  = 8,
  parameter int N_W    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              tick,
  input  logic [N_W-1:0]    last_n,
  input  logic [DIV_W-1:0]  in_div,
  input  logic [LEN_W-1:0]  in_len,
  input  frame_cfg_t        in_cfg,
  input  logic [DATA_W-1:0] in_data,
  output logic              active,
  output logic [N_W-1:0]    n,
  output logic [DIV_W-1:0]  div_q,
  output logic [LEN_W-1:0]  len_q,
  output frame_cfg_t        cfg_q,
  output logic [DATA_W-1:0] data_q
);

  logic              active_q, active_d;
  logic [N_W-1:0]    n_q, n_d;
  logic [DIV_W-1:0]  div_d;
  logic [LEN_W-1:0]  len_d;
  frame_cfg_t        cfg_d;
  logic [DATA_W-1:0] data_d;

  always_comb begin
    active_d = active_q;
    n_d      = n_q;
    div_d    = div_q;
    len_d    = len_q;
    cfg_d    = cfg_q;
    data_d   = data_q;
    if (accept) begin
      active_d = 1'b1;
      n_d      = '0;
      div_d    = (in_div < DIV_W'(2)) ? DIV_W'(2) : in_div;
      len_d    = in_len;
      cfg_d    = in_cfg;
      data_d   = in_data;
    end else if (active_q && tick) begin
      if (n_q == last_n) begin
        active_d = 1'b0;
        n_d      = '0;
      end else begin
        n_d = n_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      n_q      <= '0;
      div_q    <= DIV_W'(2);
      len_q    <= '0;
      cfg_q    <= '0;
      data_q   <= '0;
    end else begin
      active_q <= active_d;
      n_q      <= n_d;
      div_q    <= div_d;
      len_q    <= len_d;
      cfg_q    <= cfg_d;
      data_q   <= data_d;
    end
  end

  assign active = active_q;
  assign n      = n_q;

endmodule

// File: rtl/mtx_framer.sv
module mtx_framer
  import mtx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 4,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [1:0]        cfg_pre_sel,
  input  logic [LEN_W-1:0]  cfg_pre_len,
  input  logic              cfg_sync_en,
  input  logic              cfg_cmd,
  input  logic              cfg_var_sync,
  input  logic              chr_valid,
  input  logic [DATA_W-1:0] chr_data,
  input  logic              chr_cmd,
  output logic              chr_ready,
  output logic              tx_line,
  output logic              busy
);

  localparam int HALVES_MAX = 2 * ((1 << LEN_W) - 1) + 6 + 2 * DATA_W;
  localparam int N_W        = $clog2(HALVES_MAX);

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              accept;
  logic              half_tick;
  logic              active;
  logic              level;
  logic [N_W-1:0]    n;
  logic [N_W-1:0]    last_n;
  logic [DIV_W-1:0]  div_q;
  logic [LEN_W-1:0]  len_q;
  frame_cfg_t        cfg_in;
  frame_cfg_t        cfg_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  assign cfg_in.sel     = pre_e'(cfg_pre_sel);
  assign cfg_in.sync_en = cfg_sync_en;
  assign cfg_in.cmd     = cfg_var_sync ? chr_cmd : cfg_cmd;

  assign chr_ready = ~active;
  assign accept    = chr_valid & chr_ready & rst_int_n;

  mtx_tick #(.DIV_W(DIV_W)) i_tick (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .restart (accept),
    .run     (active),
    .div     (div_q),
    .tick    (half_tick)
  );

  mtx_seq #(
    .DATA_W (DATA_W),
    .LEN_W  (LEN_W),
    .DIV_W  (DIV_W),
    .N_W    (N_W)
  ) i_seq (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .accept  (accept),
    .tick    (half_tick),
    .last_n  (last_n),
    .in_div  (cfg_div),
    .in_len  (cfg_pre_len),
    .in_cfg  (cfg_in),
    .in_data (chr_data),
    .active  (active),
    .n       (n),
    .div_q   (div_q),
    .len_q   (len_q),
    .cfg_q   (cfg_q),
    .data_q  (data_q)
  );

  mtx_level #(
    .DATA_W (DATA_W),
    .LEN_W  (LEN_W),
    .N_W    (N_W)
  ) i_level (
    .n       (n),
    .pre_len (len_q),
    .cfg     (cfg_q),
    .data    (data_q),
    .level   (level),
    .last_n  (last_n)
  );

  assign tx_line = active ? level : 1'b1;
  assign busy    = active;

endmodule

// File: rtl/mtx_framer_chk.sv
module mtx_framer_chk (
  input logic clk,
  input logic rst_n,
  input logic chr_valid,
  input logic chr_ready,
  input logic busy,
  input logic tx_line,
  input logic half_tick
);

  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> tx_line);

  assert_start_on_handshake_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(chr_valid && chr_ready));

  assert_end_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(half_tick));

  assert_stable_between_ticks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(half_tick)) |-> $stable(tx_line));

endmodule

bind mtx_framer mtx_framer_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .chr_valid (chr_valid),
  .chr_ready (chr_ready),
  .busy      (busy),
  .tx_line   (tx_line),
  .half_tick (half_tick)
);

// File: tb/test_mtx_framer.sv
module test_mtx_framer;

  logic       clk;
  logic       rst_n;
  logic [7:0] cfg_div;
  logic [1:0] cfg_pre_sel;
  logic [3:0] cfg_pre_len;
  logic       cfg_sync_en;
  logic       cfg_cmd;
  logic       cfg_var_sync;
  logic       chr_valid;
  logic [7:0] chr_data;
  logic       chr_cmd;
  logic       chr_ready;
  logic       tx_line;
  logic       busy;

  int total;
  int bad;

  mtx_framer i_mtx_framer (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_div      (cfg_div),
    .cfg_pre_sel  (cfg_pre_sel),
    .cfg_pre_len  (cfg_pre_len),
    .cfg_sync_en  (cfg_sync_en),
    .cfg_cmd      (cfg_cmd),
    .cfg_var_sync (cfg_var_sync),
    .chr_valid    (chr_valid),
    .chr_data     (chr_data),
    .chr_cmd      (chr_cmd),
    .chr_ready    (chr_ready),
    .tx_line      (tx_line),
    .busy         (busy)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // {div[25:18], sel[17:16], len[15:12], sync_en[11], cmd[10], var[9], chr_cmd[8], data[7:0]}
  localparam logic [25:0] VEC [8] = '{
    {8'd3, 2'd0, 4'd3,  1'b0, 1'b0, 1'b0, 1'b0, 8'hA5},
    {8'd2, 2'd1, 4'd2,  1'b1, 1'b1, 1'b0, 1'b0, 8'h3C},
    {8'd2, 2'd2, 4'd4,  1'b1, 1'b0, 1'b0, 1'b1, 8'h81},
    {8'd4, 2'd3, 4'd5,  1'b0, 1'b0, 1'b0, 1'b0, 8'h7E},
    {8'd2, 2'd0, 4'd0,  1'b1, 1'b0, 1'b1, 1'b1, 8'h01},
    {8'd2, 2'd3, 4'd15, 1'b1, 1'b1, 1'b1, 1'b0, 8'hFF},
    {8'd0, 2'd0, 4'd1,  1'b0, 1'b0, 1'b0, 1'b0, 8'h00},
    {8'd5, 2'd0, 4'd0,  1'b0, 1'b1, 1'b0, 1'b1, 8'h55}
  };

  logic exp_l [64];
  int   exp_n;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic push(input logic b);
    exp_l[exp_n] = b;
    exp_n++;
  endtask

  task automatic build(input logic [25:0] v);
    logic c;
    exp_n = 0;
    for (int i = 0; i < int'(v[15:12]); i++) begin
      logic b;
      case (v[17:16])
        2'd0: b = 1'b1;
        2'd1: b = 1'b0;
        2'd2: b = (i % 2) == 1;
        default: b = (i % 2) == 0;
      endcase
      push(b); push(~b);
    end
    if (v[11]) begin
      c = v[9] ? v[8] : v[10];
      push(c); push(c); push(c); push(~c); push(~c); push(~c);
    end else begin
      push(1'b0); push(1'b1);
    end
    for (int i = 0; i < 8; i++) begin
      push(v[i]); push(~v[i]);
    end
  endtask

  task automatic run_frame(input logic [25:0] v, input bit perturb, input string req);
    int  d;
    int  first_bad;
    int  got_bad;
    bit  hold_ok;
    bit  bsy_ok;
    bit  len_ok;
    logic first_v [64];
    build(v);
    d = (v[25:18] < 8'd2) ? 2 : int'(v[25:18]);
    @(negedge clk);
    cfg_div      = v[25:18];
    cfg_pre_sel  = v[17:16];
    cfg_pre_len  = v[15:12];
    cfg_sync_en  = v[11];
    cfg_cmd      = v[10];
    cfg_var_sync = v[9];
    chr_cmd      = v[8];
    chr_data     = v[7:0];
    chr_valid    = 1'b1;
    @(posedge clk);
    first_bad = -1;
    got_bad   = 0;
    hold_ok   = 1'b1;
    bsy_ok    = 1'b1;
    len_ok    = 1'b1;
    for (int j = 1; j <= exp_n * d; j++) begin
      int h;
      int pos;
      @(negedge clk);
      if (j == 1) chr_valid = 1'b0;
      h   = (j - 1) / d;
      pos = (j - 1) % d;
      if (!(busy && !chr_ready)) bsy_ok = 1'b0;
      if (pos == 0) begin
        first_v[h] = tx_line;
        if (tx_line !== exp_l[h]) begin
          if (first_bad < 0) begin
            first_bad = h;
            got_bad   = tx_line;
          end
        end
      end
      if (pos == d - 1 && tx_line !== first_v[h]) hold_ok = 1'b0;
      if (perturb && h == 2 && pos == 0) begin
        chr_valid    = 1'b1;
        chr_data     = ~v[7:0];
        chr_cmd      = ~v[8];
        cfg_cmd      = ~v[10];
        cfg_sync_en  = ~v[11];
        cfg_pre_len  = v[15:12] + 4'd3;
        cfg_pre_sel  = ~v[17:16];
        cfg_div      = 8'd7;
      end
      if (perturb && h == 4 && pos == 0) chr_valid = 1'b0;
    end
    @(negedge clk);
    if (busy || !chr_ready || !tx_line) len_ok = 1'b0;
    check(first_bad < 0, req, $sformatf("half %0d level", first_bad),
          got_bad, (first_bad < 0) ? 0 : int'(exp_l[first_bad]));
    check(hold_ok, "R10", "level held through half", 0, 1);
    check(bsy_ok, "R2", "busy=1 ready=0 during frame", 0, 1);
    check(len_ok, "R3", "idle exactly at H*D", int'(busy), 0);
  endtask

  initial begin
    total = 0;
    bad   = 0;
    #4000000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n        = 1'b0;
    cfg_div      = 8'd2;
    cfg_pre_sel  = 2'd0;
    cfg_pre_len  = 4'd0;
    cfg_sync_en  = 1'b0;
    cfg_cmd      = 1'b0;
    cfg_var_sync = 1'b0;
    chr_valid    = 1'b0;
    chr_data     = 8'h00;
    chr_cmd      = 1'b0;
    repeat (3) @(negedge clk);
    check(tx_line === 1'b1 && busy === 1'b0, "R1", "line/busy in reset",
          int'({tx_line, busy}), 2);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(tx_line === 1'b1 && busy === 1'b0 && chr_ready === 1'b1, "R1",
          "idle after reset", int'({tx_line, busy, chr_ready}), 5);

    for (int i = 0; i < 8; i++) begin
      run_frame(VEC[i], 1'b0, "R4/R5/R6/R7/R8");
    end

    // R9: inputs disturbed mid-frame, including a valid that must not be taken
    run_frame({8'd3, 2'd2, 4'd2, 1'b1, 1'b1, 1'b0, 1'b0, 8'hC6}, 1'b1, "R9");
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && tx_line === 1'b1, "R9", "no frame from valid while busy",
          int'(busy), 0);

    // R8: variable sync with global bit opposite, data sync expected
    run_frame({8'd2, 2'd1, 4'd1, 1'b1, 1'b1, 1'b1, 1'b0, 8'h92}, 1'b0, "R8");

    // R1: reset mid-frame
    @(negedge clk);
    cfg_div   = 8'd3;
    cfg_pre_len = 4'd4;
    chr_valid = 1'b1;
    @(negedge clk);
    chr_valid = 1'b0;
    repeat (5) @(negedge clk);
    check(busy === 1'b1, "R2", "busy mid-frame before reset", int'(busy), 1);
    rst_n = 1'b0;
    @(negedge clk);
    check(busy === 1'b0 && tx_line === 1'b1 && chr_ready === 1'b1, "R1",
          "idle after mid-frame reset", int'({tx_line, busy, chr_ready}), 5);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // back-to-back: a frame right after reset recovery still frames correctly
    run_frame({8'd2, 2'd3, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h6B}, 1'b0, "R4/R6");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule